// File: doc/BRIEF.md
# Real-Time Counter with Alarm

This block keeps time against a slow real-time tick. A 32-bit counter advances once per tick while the run enable is set, and an alarm fires when alarms are armed and the counter reaches a programmed compare value. The block runs in one of two modes. In free-running mode the counter is never disturbed by an alarm. It wraps from all-ones to zero, and software moves the compare value ahead by an interval using unsigned wrap-around arithmetic. In auto-reset mode the hardware returns the counter to zero on every match, so the compare value becomes a fixed repeating period.

Software drives the block through a few write strobes. One strobe writes the configuration (run, arm, mode). Another writes the compare value, and this write is accepted only while alarms are disarmed. A third loads the counter directly. The block reports an alarm event flag that lasts at most one tick, a sticky interrupt pending bit, and a one-cycle overflow pulse. Software uses the overflow pulse to keep an upper count word.

The whole block runs on one clock, and `tick` qualifies the real-time advance.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the counter and compare value are zero; run, arm and auto-reset are off; `alarmEvent`, `irqPending` and `overflowPulse` are low.
- R2: On a clock edge with `tick` high, the run enable set and no load, the counter increases by one. Otherwise it holds.
- R3: `cntLoad` writes `loadData` into the counter on that edge. It takes priority over incrementing, and no alarm or overflow is detected on that edge.
- R4: A match is an edge with `tick` high, run set, alarms armed, no load, and counter equal to the compare value. A match sets `alarmEvent` and `irqPending` on that edge.
- R5: In free-running mode (`cfgAutoReset`=0), a match does not disturb the counter, which goes on to compare value plus one.
- R6: In auto-reset mode (`cfgAutoReset`=1), the counter becomes zero on the match edge. The alarm period is therefore compare value plus one ticks.
- R7: `alarmEvent` drops at the next edge with `tick` high that is not itself a match. A configuration write with `cfgAlarmEn`=0 clears it at once, and this takes priority over a match on the same edge.
- R8: A compare write is ignored while alarms are armed. It takes effect only while they are disarmed.
- R9: `irqPending` stays set until an edge with `irqClear` high. If a match occurs on that same edge, the bit stays set.
- R10: `overflowPulse` is high for one cycle after an edge on which the counter advances from all-ones to zero in free-running mode. It never fires in auto-reset mode.
- R11: Disarming and re-arming after an alarm without a new compare value gives no alarm until the counter comes round to the compare value again.
- R12: Configuration fields written on an edge take effect from the next edge. The match on the write edge uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Real-time advance qualifier, one clock wide per tick |
| cfgWrite | input | 1 | Strobe: write the three configuration fields |
| cfgRunEn | input | 1 | Configuration: counter runs |
| cfgAlarmEn | input | 1 | Configuration: alarms armed |
| cfgAutoReset | input | 1 | Configuration: 1 = auto-reset mode, 0 = free-running |
| cmpWrite | input | 1 | Strobe: write compare value (ignored while armed) |
| cmpData | input | 32 | Compare value to write |
| cntLoad | input | 1 | Strobe: load the counter |
| loadData | input | 32 | Counter load value |
| irqClear | input | 1 | Strobe: clear interrupt pending |
| count | output | 32 | Current counter value |
| cmpValue | output | 32 | Current compare value |
| alarmEvent | output | 1 | Alarm event flag, at most one tick long |
| irqPending | output | 1 | Sticky interrupt pending |
| overflowPulse | output | 1 | One-cycle pulse on a free-running wrap |

## Verification
Every output is a register, so the effect of inputs held across a rising edge becomes visible right after that edge. Only `alarmEvent` can persist beyond that, and it persists until the next tick edge. The bench drives inputs on the falling edge and steps a requirement-level model on the rising edge. It compares all five outputs on the following falling edge, so each expected value is checked exactly one edge after its cause. Directed steps then confirm the multi-edge results: the zero after a match in auto-reset mode, the silent stretch after re-arming, and the one-cycle width of the overflow pulse.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  typedef struct packed {
    logic cntLoad;
    logic cntClear;
    logic cntIncr;
    logic cmpWrite;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobes_t      strobes,
  input  logic [WIDTH-1:0] loadData,
  input  logic [WIDTH-1:0] cmpData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cmpValue,
  output logic             atMatch,
  output logic             atMax
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.cntLoad) begin
      count <= loadData;
    end else if (strobes.cntClear) begin
      count <= '0;
    end else if (strobes.cntIncr) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValue <= '0;
    end else if (strobes.cmpWrite) begin
      cmpValue <= cmpData;
    end
  end

  assign atMatch = (count == cmpValue);
  assign atMax   = &count;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntLoad |=> count == $past(loadData)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntIncr && !strobes.cntLoad) |=> count == WIDTH'($past(count) + ONE)); // R2
  AST_AUTO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntClear && !strobes.cntLoad) |=> count == '0); // R6
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cmpWrite |=> $stable(cmpValue)); // R8
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        cfgWrite,
  input  logic        cfgRunEn,
  input  logic        cfgAlarmEn,
  input  logic        cfgAutoReset,
  input  logic        cmpWrite,
  input  logic        cntLoad,
  input  logic        irqClear,
  input  logic        atMatch,
  input  logic        atMax,
  output rtcStrobes_t strobes,
  output logic        alarmEvent,
  output logic        irqPending,
  output logic        overflowPulse
);
  logic runEn;
  logic alarmEn;
  logic autoReset;
  logic advance;
  logic hit;
  logic disarm;
  logic wrap;

  always_comb begin
    advance = tick && runEn && !cntLoad;
    hit     = advance && alarmEn && atMatch;
    disarm  = cfgWrite && !cfgAlarmEn;
    wrap    = advance && !autoReset && atMax;

    strobes.cntLoad  = cntLoad;
    strobes.cntClear = hit && autoReset;
    strobes.cntIncr  = advance && !(hit && autoReset);
    strobes.cmpWrite = cmpWrite && !alarmEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      alarmEn   <= 1'b0;
      autoReset <= 1'b0;
    end else if (cfgWrite) begin
      runEn     <= cfgRunEn;
      alarmEn   <= cfgAlarmEn;
      autoReset <= cfgAutoReset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmEvent <= 1'b0;
    end else if (disarm) begin
      alarmEvent <= 1'b0;
    end else if (hit) begin
      alarmEvent <= 1'b1;
    end else if (tick) begin
      alarmEvent <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (hit) begin
      irqPending <= 1'b1;
    end else if (irqClear) begin
      irqPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowPulse <= 1'b0;
    end else begin
      overflowPulse <= wrap;
    end
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmEvent) |-> irqPending); // R9
  AST_EVENT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (alarmEvent && tick && !hit) |=> !alarmEvent); // R7
  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    disarm |=> !alarmEvent); // R7
  AST_OVF_FREE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> $past(!autoReset)); // R10
  AST_NO_ARMED_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (alarmEn && cmpWrite) |-> !strobes.cmpWrite); // R8
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_alarm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             cfgWrite,
  input  logic             cfgRunEn,
  input  logic             cfgAlarmEn,
  input  logic             cfgAutoReset,
  input  logic             cmpWrite,
  input  logic [WIDTH-1:0] cmpData,
  input  logic             cntLoad,
  input  logic [WIDTH-1:0] loadData,
  input  logic             irqClear,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cmpValue,
  output logic             alarmEvent,
  output logic             irqPending,
  output logic             overflowPulse
);
  rtcStrobes_t strobes;
  logic        atMatch;
  logic        atMax;

  rtc_alarm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .cfgWrite     (cfgWrite),
    .cfgRunEn     (cfgRunEn),
    .cfgAlarmEn   (cfgAlarmEn),
    .cfgAutoReset (cfgAutoReset),
    .cmpWrite     (cmpWrite),
    .cntLoad      (cntLoad),
    .irqClear     (irqClear),
    .atMatch      (atMatch),
    .atMax        (atMax),
    .strobes      (strobes),
    .alarmEvent   (alarmEvent),
    .irqPending   (irqPending),
    .overflowPulse(overflowPulse)
  );

  rtc_alarm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadData(loadData),
    .cmpData (cmpData),
    .count   (count),
    .cmpValue(cmpValue),
    .atMatch (atMatch),
    .atMax   (atMax)
  );
endmodule

// File: tb/sim_rtc_alarm_timer.sv
`timescale 1ns/1ps
module sim_rtc_alarm_timer;
  localparam int W = 32;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, cfgWrite = 1'b0, cfgRunEn = 1'b0, cfgAlarmEn = 1'b0, cfgAutoReset = 1'b0;
  logic cmpWrite = 1'b0, cntLoad = 1'b0, irqClear = 1'b0;
  logic [W-1:0] cmpData = '0, loadData = '0;
  logic [W-1:0] count, cmpValue;
  logic alarmEvent, irqPending, overflowPulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_alarm_timer #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgWrite(cfgWrite), .cfgRunEn(cfgRunEn),
    .cfgAlarmEn(cfgAlarmEn), .cfgAutoReset(cfgAutoReset), .cmpWrite(cmpWrite),
    .cmpData(cmpData), .cntLoad(cntLoad), .loadData(loadData), .irqClear(irqClear),
    .count(count), .cmpValue(cmpValue), .alarmEvent(alarmEvent),
    .irqPending(irqPending), .overflowPulse(overflowPulse)
  );

  // requirement-level model, advanced on each rising edge
  logic [W-1:0] mCount, mCmp;
  logic mRun, mAlm, mAuto, mEvt, mIrq, mOvf;

  function automatic logic [W-1:0] nextCount(logic [W-1:0] cur, logic ld, logic [W-1:0] ldv,
                                              logic adv, logic hit, logic autoMode);
    if (ld) return ldv;                 // R3
    if (hit && autoMode) return '0;     // R6
    if (adv) return cur + 1;            // R2, R5
    return cur;
  endfunction

  always @(posedge clk) begin
    logic adv, hit, wrap;
    if (!rstN) begin
      mCount = '0; mCmp = '0; mRun = 0; mAlm = 0; mAuto = 0; mEvt = 0; mIrq = 0; mOvf = 0;
    end else begin
      adv  = tick && mRun && !cntLoad;
      hit  = adv && mAlm && (mCount == mCmp);
      wrap = adv && !mAuto && (mCount == ALL1);
      if (cmpWrite && !mAlm) mCmp = cmpData;
      if (cfgWrite && !cfgAlarmEn) mEvt = 0;
      else if (hit) mEvt = 1;
      else if (tick) mEvt = 0;
      if (hit) mIrq = 1;
      else if (irqClear) mIrq = 0;
      mOvf = wrap;
      mCount = nextCount(mCount, cntLoad, loadData, adv, hit, mAuto);
      if (cfgWrite) begin mRun = cfgRunEn; mAlm = cfgAlarmEn; mAuto = cfgAutoReset; end // R12
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R2 count", count, mCount);
    check("R8 cmpValue", cmpValue, mCmp);
    check("R7 alarmEvent", W'(alarmEvent), W'(mEvt));
    check("R9 irqPending", W'(irqPending), W'(mIrq));
    check("R10 overflowPulse", W'(overflowPulse), W'(mOvf));
  endtask

  task automatic clearIn();
    tick = 0; cfgWrite = 0; cmpWrite = 0; cntLoad = 0; irqClear = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    clearIn();
  endtask

  task automatic cfg(logic r, logic a, logic au);
    cfgWrite = 1; cfgRunEn = r; cfgAlarmEn = a; cfgAutoReset = au;
    step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int evCount;
    void'($urandom(32'h5eed_1234));
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 count", count, '0);
    check("R1 cmpValue", cmpValue, '0);
    check("R1 flags", W'({alarmEvent, irqPending, overflowPulse}), '0);

    cfg(1, 0, 0);
    ticks(5);
    check("R2 five ticks", count, W'(5));
    step();
    check("R2 hold without tick", count, W'(5));
    cntLoad = 1; loadData = W'(100); tick = 1; step();
    check("R3 load wins over tick", count, W'(100));

    cmpWrite = 1; cmpData = W'(105); step();
    check("R8 write while disarmed", cmpValue, W'(105));
    cfg(1, 1, 0);
    ticks(5);
    check("R4 no early alarm", W'(alarmEvent), '0);
    ticks(1);
    check("R4 alarm on match", W'({alarmEvent, irqPending}), W'(2'b11));
    check("R5 counter passes match", count, W'(106));
    step();
    check("R7 held between ticks", W'(alarmEvent), W'(1));
    ticks(1);
    check("R7 drops on next tick", W'(alarmEvent), '0);

    cmpWrite = 1; cmpData = W'(200); step();
    check("R8 write ignored while armed", cmpValue, W'(105));
    irqClear = 1; step();
    check("R9 cleared", W'(irqPending), '0);

    cfg(1, 0, 0);
    cfg(1, 1, 0);
    evCount = 0;
    for (int i = 0; i < 20; i++) begin tick = 1; step(); if (alarmEvent) evCount++; end
    check("R11 no alarm after rearm", W'(evCount), '0);

    cntLoad = 1; loadData = W'(104); step();
    ticks(2);
    check("R4 second alarm", W'(alarmEvent), W'(1));
    cfg(1, 0, 0);
    check("R7 disarm clears event", W'(alarmEvent), '0);

    cfg(1, 0, 1);
    cmpWrite = 1; cmpData = W'(3); step();
    cntLoad = 1; loadData = '0; step();
    cfg(1, 1, 1);
    ticks(4);
    check("R6 auto zero on match", count, '0);
    check("R6 event", W'(alarmEvent), W'(1));
    ticks(3);
    check("R6 period climbs", count, W'(3));
    tick = 1; irqClear = 1; step();
    check("R9 alarm beats clear", W'(irqPending), W'(1));
    check("R6 second wrap", count, '0);

    cfg(1, 0, 0);
    cntLoad = 1; loadData = ALL1; step();
    ticks(1);
    check("R10 wrap pulse", W'(overflowPulse), W'(1));
    check("R10 wraps to zero", count, '0);
    step();
    check("R10 one cycle", W'(overflowPulse), '0);
    cfg(1, 0, 1);
    cntLoad = 1; loadData = ALL1; step();
    ticks(1);
    check("R10 none in auto mode", W'(overflowPulse), '0);

    // constrained random phase, checked every cycle against the model
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 3) != 0;
      if ($urandom % 16 == 0) begin
        cfgWrite = 1; cfgRunEn = ($urandom % 8) != 0;
        cfgAlarmEn = $urandom % 2; cfgAutoReset = $urandom % 2;
      end
      if ($urandom % 8 == 0) begin
        cmpWrite = 1;
        cmpData = ($urandom % 4 == 0) ? ALL1 - W'($urandom % 4) : W'($urandom % 16);
      end
      if ($urandom % 16 == 0) begin
        cntLoad = 1;
        loadData = ($urandom % 3 == 0) ? ALL1 - W'($urandom % 4) : W'($urandom % 16);
      end
      irqClear = ($urandom % 8) == 0;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule